// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed master for serial flash memories. Software loads a
job into a few host-visible registers and then writes a start bit. A job is an opcode
byte, an optional address of up to four bytes, a run of dummy clocks and a data phase of
up to one buffer's worth of bytes. The engine then runs the whole job on a single-lane
SPI link and raises a busy flag until the chip select is released. In the data phase it
either sends bytes from a local byte buffer or fills that buffer with bytes from the
flash. The direction is fixed for the whole job.

The host side is a word-wide register port with byte enables. Read data follows the word
address in the same cycle. After reset the engine is in automatic mode, and a start is
refused. To reach manual mode the host must write the command register with 0x55 and then
with 0xAA, and only after that clear the two mode bits. The flash side uses SPI mode 0
with two active-low chip selects.

Top module: `spi_cmd_engine`

## Requirements
- R1: Register words (byte offset = 4 × word index) and their reset values:
  - Word 0 is configuration and resets to 0. Bits 18:16 are the address length, bits 23:19 the dummy count and bit 24 the chip select.
  - Word 1 holds control in byte 0, the opcode in byte 1 and the data count in byte 2. Control bit 0 starts a job and always reads 0. Bit 1 is busy and is read-only. Bit 3 is the direction. Bits 5:4 are the mode bits and reset to 11, so word 1 reads 0x00000030 after reset.
  - Word 2 is the address.
  - Words 16 to 31 are the 64-byte buffer. Within a word, buffer byte 4w+k sits in bits 8k+7:8k.
- R2: Clearing control bits 5:4 takes effect only when the two most recent command-register writes were 0x55 and then 0xAA. The clear uses up that unlock. Writing 11 to bits 5:4 is always accepted.
- R3: Writing control bit 0 as 1 starts a job only when bits 5:4 read 00 and the engine is idle. Busy then reads 1 until the chip select has been released.
- R4: A job is sent in this order, each byte MSB first:
  - the opcode;
  - the address, with as many bytes as the address length gives (any value above 4 counts as 4), taken from the low bytes of the address register with the most significant byte first;
  - as many dummy clocks as the dummy count gives, with MOSI held low.
- R5: With direction 1 the data phase sends buffer bytes 0 to n-1. With direction 0 it drives MOSI low and stores the received bytes in buffer bytes 0 to n-1.
- R6: A data count of 0 gives a job with no data phase. A count above 64 is treated as 64.
- R7: Configuration bit 24 = 0 asserts chip select 0, and 1 asserts chip select 1. At most one chip select is low at any time, and both are high while idle.
- R8: SCLK rests low. The chip select falls at least one clock before the first rising SCLK edge. MOSI changes only while SCLK is low. MISO is sampled while SCLK is high. The chip select rises one clock after the last falling edge.
- R9: While busy, writes to configuration, control, opcode, count, address and buffer have no effect, and a start request is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hst_word_i | input | 5 | Host word address |
| hst_wr_i | input | 1 | Host write strobe |
| hst_be_i | input | 4 | Byte enables for the write |
| hst_wdata_i | input | 32 | Host write data |
| hst_rdata_o | output | 32 | Read data for hst_word_i |
| spi_sclk_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| spi_csn_o | output | 2 | Active-low chip selects |

## Verification
The engine is exercised with several job shapes:
- an opcode-only job;
- a 3-byte-address write on the second chip select;
- a fast read with eight dummy clocks that fills all 64 bytes;
- a job whose address length is out of range, which must behave as a 4-byte address;
- a job whose count exceeds the buffer.

Comparing the serial stream bit by bit against an independent model tells apart:
- phase-ordering faults;
- byte-order faults;
- off-by-one faults in the address, dummy and data counters.

The fill pattern changes with both byte index and seed, so a received byte stored at the wrong buffer position shows up as a mismatch.

Separate register-port sequences cover the rest:
- a correct unlock;
- a broken unlock;
- relocking;
- writes made while a job is running.

// File: rtl/sce_pkg.sv
package sce_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_OPC,
        PH_ADR,
        PH_DUM,
        PH_DAT,
        PH_TAIL
    } sce_phase_e;

    typedef struct packed {
        logic        cs_sel;
        logic [4:0]  dummy;
        logic [2:0]  alen;
        logic        tx_dir;
        logic [7:0]  opcode;
        logic [31:0] addr;
        logic [7:0]  count;
    } sce_job_t;

    localparam logic [7:0] UNLOCK_FIRST  = 8'h55;
    localparam logic [7:0] UNLOCK_SECOND = 8'hAA;
    localparam logic [2:0] ALEN_MAX      = 3'd4;

    function automatic logic [2:0] eff_alen(input logic [2:0] a);
        return (a > ALEN_MAX) ? ALEN_MAX : a;
    endfunction

    function automatic logic [7:0] eff_count(input logic [7:0] c, input logic [7:0] lim);
        return (c > lim) ? lim : c;
    endfunction

    function automatic logic [7:0] addr_byte(input logic [31:0] a, input logic [2:0] alen,
                                             input logic [1:0] idx);
        logic [2:0] sel;
        sel = alen - 3'd1 - {1'b0, idx};
        case (sel[1:0])
            2'd0:    return a[7:0];
            2'd1:    return a[15:8];
            2'd2:    return a[23:16];
            default: return a[31:24];
        endcase
    endfunction

endpackage

// File: rtl/sce_regs.sv
module sce_regs
    import sce_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    localparam int IDX_W = $clog2(BUF_BYTES),
    localparam int WA_W  = IDX_W - 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WA_W-1:0]  hst_word_i,
    input  logic             hst_wr_i,
    input  logic [3:0]       hst_be_i,
    input  logic [31:0]      hst_wdata_i,
    output logic [31:0]      hst_rdata_o,
    input  logic             busy_i,
    output logic             start_o,
    output sce_job_t         job_o,
    output logic [1:0]       mode_o,
    input  logic [IDX_W-1:0] buf_idx_i,
    input  logic             rx_we_i,
    input  logic [7:0]       rx_byte_i,
    output logic [7:0]       tx_byte_o
);

    logic        cs_sel_q;
    logic [4:0]  dum_q;
    logic [2:0]  alen_q;
    logic        dir_q;
    logic [1:0]  mode_q;
    logic [7:0]  opc_q;
    logic [7:0]  cnt_q;
    logic [31:0] adr_q;
    logic        saw_first_q;
    logic        armed_q;
    logic [7:0]  buf_q [BUF_BYTES];

    logic is_buf, sel_cfg, sel_ctl, sel_adr, wr_ok;

    assign is_buf  = hst_word_i[WA_W-1];
    assign sel_cfg = (hst_word_i == WA_W'(0));
    assign sel_ctl = (hst_word_i == WA_W'(1));
    assign sel_adr = (hst_word_i == WA_W'(2));
    assign wr_ok   = hst_wr_i && !busy_i;

    assign start_o = wr_ok && sel_ctl && hst_be_i[0] && hst_wdata_i[0] && (mode_q == 2'b00);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cs_sel_q    <= 1'b0;
            dum_q       <= '0;
            alen_q      <= '0;
            dir_q       <= 1'b0;
            mode_q      <= 2'b11;
            opc_q       <= '0;
            cnt_q       <= '0;
            adr_q       <= '0;
            saw_first_q <= 1'b0;
            armed_q     <= 1'b0;
        end else if (wr_ok) begin
            if (sel_cfg) begin
                if (hst_be_i[2]) begin
                    alen_q <= hst_wdata_i[18:16];
                    dum_q  <= hst_wdata_i[23:19];
                end
                if (hst_be_i[3]) cs_sel_q <= hst_wdata_i[24];
            end
            if (sel_ctl) begin
                if (hst_be_i[0]) begin
                    dir_q <= hst_wdata_i[3];
                    if (hst_wdata_i[5:4] == 2'b11) begin
                        mode_q <= 2'b11;
                    end else if (armed_q) begin
                        mode_q  <= hst_wdata_i[5:4];
                        armed_q <= 1'b0;
                    end
                end
                if (hst_be_i[1]) begin
                    opc_q <= hst_wdata_i[15:8];
                    if (hst_wdata_i[15:8] == UNLOCK_FIRST) begin
                        saw_first_q <= 1'b1;
                        armed_q     <= 1'b0;
                    end else if (hst_wdata_i[15:8] == UNLOCK_SECOND && saw_first_q) begin
                        saw_first_q <= 1'b0;
                        armed_q     <= 1'b1;
                    end else begin
                        saw_first_q <= 1'b0;
                        armed_q     <= 1'b0;
                    end
                end
                if (hst_be_i[2]) cnt_q <= hst_wdata_i[23:16];
            end
            if (sel_adr) begin
                for (int k = 0; k < 4; k++) begin
                    if (hst_be_i[k]) adr_q[8*k +: 8] <= hst_wdata_i[8*k +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rx_we_i) begin
            buf_q[buf_idx_i] <= rx_byte_i;
        end else if (wr_ok && is_buf) begin
            for (int k = 0; k < 4; k++) begin
                if (hst_be_i[k]) buf_q[{hst_word_i[IDX_W-3:0], 2'(k)}] <= hst_wdata_i[8*k +: 8];
            end
        end
    end

    assign tx_byte_o = buf_q[buf_idx_i];

    always_comb begin
        hst_rdata_o = '0;
        if (is_buf) begin
            for (int k = 0; k < 4; k++) begin
                hst_rdata_o[8*k +: 8] = buf_q[{hst_word_i[IDX_W-3:0], 2'(k)}];
            end
        end else if (sel_cfg) begin
            hst_rdata_o[24]    = cs_sel_q;
            hst_rdata_o[23:19] = dum_q;
            hst_rdata_o[18:16] = alen_q;
        end else if (sel_ctl) begin
            hst_rdata_o = {8'h00, cnt_q, opc_q, 2'b00, mode_q, dir_q, 1'b0, busy_i, 1'b0};
        end else if (sel_adr) begin
            hst_rdata_o = adr_q;
        end
    end

    always_comb begin
        job_o.cs_sel = cs_sel_q;
        job_o.dummy  = dum_q;
        job_o.alen   = alen_q;
        job_o.tx_dir = dir_q;
        job_o.opcode = opc_q;
        job_o.addr   = adr_q;
        job_o.count  = cnt_q;
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/sce_seq.sv
module sce_seq
    import sce_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    localparam int IDX_W = $clog2(BUF_BYTES)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  sce_job_t         job_i,
    input  logic [7:0]       tx_byte_i,
    output logic [IDX_W-1:0] buf_idx_o,
    output logic             rx_we_o,
    output logic [7:0]       rx_byte_o,
    output logic             busy_o,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic [1:0]       csn_o,
    input  logic             miso_i
);

    sce_phase_e ph_q;
    logic       half_q;
    logic       sclk_q;
    logic [2:0] bit_q;
    logic [7:0] cnt_q;
    logic [6:0] shr_q;

    logic [2:0] alen_e;
    logic [7:0] cnt_e;
    logic       has_adr, has_dum, has_dat;
    sce_phase_e nx_opc, nx_adr, nx_dum;
    logic [7:0] cur_byte;

    assign alen_e  = eff_alen(job_i.alen);
    assign cnt_e   = eff_count(job_i.count, 8'(BUF_BYTES));
    assign has_adr = (alen_e != 3'd0);
    assign has_dum = (job_i.dummy != 5'd0);
    assign has_dat = (cnt_e != 8'd0);

    assign nx_dum = has_dat ? PH_DAT : PH_TAIL;
    assign nx_adr = has_dum ? PH_DUM : nx_dum;
    assign nx_opc = has_adr ? PH_ADR : nx_adr;

    always_comb begin
        case (ph_q)
            PH_OPC:  cur_byte = job_i.opcode;
            PH_ADR:  cur_byte = addr_byte(job_i.addr, alen_e, cnt_q[1:0]);
            PH_DAT:  cur_byte = job_i.tx_dir ? tx_byte_i : 8'h00;
            default: cur_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q   <= PH_IDLE;
            half_q <= 1'b0;
            sclk_q <= 1'b0;
            bit_q  <= 3'd7;
            cnt_q  <= '0;
            shr_q  <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (start_i) begin
                        ph_q   <= PH_LEAD;
                        half_q <= 1'b0;
                        bit_q  <= 3'd7;
                        cnt_q  <= '0;
                    end
                end
                PH_LEAD: ph_q <= PH_OPC;
                PH_TAIL: ph_q <= PH_IDLE;
                default: begin
                    if (!half_q) begin
                        sclk_q <= 1'b1;
                        half_q <= 1'b1;
                    end else begin
                        sclk_q <= 1'b0;
                        half_q <= 1'b0;
                        shr_q  <= {shr_q[5:0], miso_i};
                        if (ph_q == PH_DUM) begin
                            if (cnt_q == {3'b000, job_i.dummy} - 8'd1) begin
                                ph_q  <= nx_dum;
                                cnt_q <= '0;
                            end else begin
                                cnt_q <= cnt_q + 8'd1;
                            end
                        end else if (bit_q != 3'd0) begin
                            bit_q <= bit_q - 3'd1;
                        end else begin
                            bit_q <= 3'd7;
                            case (ph_q)
                                PH_OPC: begin
                                    ph_q  <= nx_opc;
                                    cnt_q <= '0;
                                end
                                PH_ADR: begin
                                    if (cnt_q == {5'b00000, alen_e} - 8'd1) begin
                                        ph_q  <= nx_adr;
                                        cnt_q <= '0;
                                    end else begin
                                        cnt_q <= cnt_q + 8'd1;
                                    end
                                end
                                default: begin
                                    if (cnt_q == cnt_e - 8'd1) ph_q <= PH_TAIL;
                                    else cnt_q <= cnt_q + 8'd1;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    assign busy_o    = (ph_q != PH_IDLE);
    assign sclk_o    = sclk_q;
    assign mosi_o    = (ph_q == PH_OPC || ph_q == PH_ADR || ph_q == PH_DAT) ? cur_byte[bit_q] : 1'b0;
    assign csn_o[0]  = !(busy_o && !job_i.cs_sel);
    assign csn_o[1]  = !(busy_o && job_i.cs_sel);
    assign buf_idx_o = cnt_q[IDX_W-1:0];
    assign rx_we_o   = (ph_q == PH_DAT) && half_q && (bit_q == 3'd0) && !job_i.tx_dir;
    assign rx_byte_o = {shr_q, miso_i};

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import sce_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    localparam int IDX_W = $clog2(BUF_BYTES),
    localparam int WA_W  = IDX_W - 1
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [WA_W-1:0] hst_word_i,
    input  logic            hst_wr_i,
    input  logic [3:0]      hst_be_i,
    input  logic [31:0]     hst_wdata_i,
    output logic [31:0]     hst_rdata_o,
    output logic            spi_sclk_o,
    output logic            spi_mosi_o,
    input  logic            spi_miso_i,
    output logic [1:0]      spi_csn_o
);

    sce_job_t         job_w;
    logic [1:0]       mode_w;
    logic             busy_w;
    logic             start_w;
    logic [IDX_W-1:0] idx_w;
    logic             rx_we_w;
    logic [7:0]       rx_byte_w;
    logic [7:0]       tx_byte_w;

    sce_regs #(.BUF_BYTES(BUF_BYTES)) u_regs (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .hst_word_i  (hst_word_i),
        .hst_wr_i    (hst_wr_i),
        .hst_be_i    (hst_be_i),
        .hst_wdata_i (hst_wdata_i),
        .hst_rdata_o (hst_rdata_o),
        .busy_i      (busy_w),
        .start_o     (start_w),
        .job_o       (job_w),
        .mode_o      (mode_w),
        .buf_idx_i   (idx_w),
        .rx_we_i     (rx_we_w),
        .rx_byte_i   (rx_byte_w),
        .tx_byte_o   (tx_byte_w)
    );

    sce_seq #(.BUF_BYTES(BUF_BYTES)) u_seq (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .start_i   (start_w),
        .job_i     (job_w),
        .tx_byte_i (tx_byte_w),
        .buf_idx_o (idx_w),
        .rx_we_o   (rx_we_w),
        .rx_byte_o (rx_byte_w),
        .busy_o    (busy_w),
        .sclk_o    (spi_sclk_o),
        .mosi_o    (spi_mosi_o),
        .csn_o     (spi_csn_o),
        .miso_i    (spi_miso_i)
    );

endmodule

// File: rtl/sce_chk.sv
module sce_chk
    import sce_pkg::*;
(
    input logic       clk_i,
    input logic       rst_i,
    input logic       busy_i,
    input logic       sclk_i,
    input logic       mosi_i,
    input logic [1:0] csn_i,
    input logic [1:0] mode_i,
    input sce_job_t   job_i
);

    AST_ONE_SELECT: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(~csn_i) <= 1); // R7

    AST_IDLE_DESELECT: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_i |-> (csn_i == 2'b11)); // R7

    AST_SCLK_PARKED: assert property (@(posedge clk_i) disable iff (rst_i)
        (csn_i == 2'b11) |-> !sclk_i); // R8

    AST_MOSI_STEADY: assert property (@(posedge clk_i) disable iff (rst_i)
        sclk_i |-> $stable(mosi_i)); // R8

    AST_CS_LEADS_CLOCK: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(csn_i[0]) || $fell(csn_i[1])) |-> !sclk_i); // R8

    AST_LAUNCH_MANUAL: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_i) |-> ($past(mode_i) == 2'b00)); // R3

    AST_JOB_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_i && $past(busy_i)) |-> $stable(job_i)); // R9

endmodule

bind spi_cmd_engine sce_chk u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .busy_i (busy_w),
    .sclk_i (spi_sclk_o),
    .mosi_i (spi_mosi_o),
    .csn_i  (spi_csn_o),
    .mode_i (mode_w),
    .job_i  (job_w)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  word = '0;
    logic        wr = 1'b0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sclk, mosi, miso;
    logic [1:0]  csn;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] tb_buf [64];

    bit   exp_q [$];
    int   mism = 0;
    int   seen = 0;
    int   rc = 0;
    int   pre_bits = 0;
    logic [7:0] seed = 8'h00;
    logic [1:0] cs_used = 2'b11;
    realtime t_fall = 0;
    bit   gap_ok = 0;
    logic csall;

    always #5 clk = ~clk;

    spi_cmd_engine dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .hst_word_i  (word),
        .hst_wr_i    (wr),
        .hst_be_i    (be),
        .hst_wdata_i (wdata),
        .hst_rdata_o (rdata),
        .spi_sclk_o  (sclk),
        .spi_mosi_o  (mosi),
        .spi_miso_i  (miso),
        .spi_csn_o   (csn)
    );

    assign csall = csn[0] & csn[1];

    function automatic logic [7:0] pat(input int i, input logic [7:0] s);
        return 8'((i * 29) + s) ^ 8'hA5;
    endfunction

    function automatic logic sbit(input int k);
        int j;
        logic [7:0] b;
        if (k < pre_bits) return 1'b0;
        j = k - pre_bits;
        b = pat(j / 8, seed);
        return b[7 - (j % 8)];
    endfunction

    // Flash model and scoreboard monitor
    initial miso = 1'b0;
    always @(posedge sclk or negedge sclk or posedge csall or negedge csall) begin
        if (csall === 1'b1) begin
            rc = 0;
            miso = 1'b0;
        end else if (csall === 1'b0) begin
            if (sclk === 1'b1) begin
                if (rc == 0) gap_ok = (($realtime - t_fall) >= 10.0);
                if (exp_q.size() == 0) mism++;
                else if (exp_q.pop_front() !== mosi) mism++;
                seen++;
                rc++;
            end else begin
                if (rc == 0) begin
                    t_fall = $realtime;
                    cs_used = csn;
                end
                miso = sbit(rc);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] w, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        word = w; wdata = d; be = b; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; be = '0;
    endtask

    task automatic bus_rd(input logic [4:0] w, output logic [31:0] d);
        @(negedge clk);
        word = w;
        #1;
        d = rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int k = 0; k < 5000; k++) begin
            bus_rd(5'd1, d);
            if (!d[1]) break;
        end
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
    endtask

    task automatic fill_buf(input logic [7:0] s);
        for (int w = 0; w < 16; w++) begin
            logic [31:0] d;
            for (int k = 0; k < 4; k++) begin
                tb_buf[4*w+k] = pat(4*w+k, s) ^ 8'h3C;
                d[8*k +: 8] = tb_buf[4*w+k];
            end
            bus_wr(5'(16 + w), d, 4'hF);
        end
    endtask

    task automatic chk_buf(input string req);
        logic [31:0] d;
        int errs = 0;
        for (int w = 0; w < 16; w++) begin
            bus_rd(5'(16 + w), d);
            for (int k = 0; k < 4; k++) if (d[8*k +: 8] !== tb_buf[4*w+k]) errs++;
        end
        chk({req, " buffer bytes wrong"}, errs, 0);
    endtask

    // Driver: programs a job, pushes the expected MOSI stream, starts it, checks it
    task automatic run_job(input string req, input logic [7:0] op, input logic [2:0] alen,
                           input logic [4:0] dum, input logic [7:0] n, input logic tx,
                           input logic cs, input logic [31:0] adr, input logic [7:0] sd,
                           input bit poke);
        int ae, ne, nbits;
        logic [31:0] d, cfg;
        ae = (alen > 4) ? 4 : int'(alen);
        ne = (n > 64) ? 64 : int'(n);
        cfg = {7'b0, cs, dum, alen, 16'h0};
        bus_wr(5'd0, cfg, 4'hF);
        bus_wr(5'd2, adr, 4'hF);
        bus_wr(5'd1, {8'h00, n, op, 8'h00}, 4'b0110);
        exp_q.delete();
        mism = 0; seen = 0; gap_ok = 0; cs_used = 2'b11;
        pre_bits = 8 + 8 * ae + int'(dum);
        seed = sd;
        push_byte(op);
        for (int b = ae - 1; b >= 0; b--) push_byte(adr[8*b +: 8]);
        for (int b = 0; b < int'(dum); b++) exp_q.push_back(1'b0);
        for (int b = 0; b < ne; b++) push_byte(tx ? tb_buf[b] : 8'h00);
        nbits = exp_q.size();
        bus_wr(5'd1, {28'h0, tx, 3'b001}, 4'b0001);
        if (poke) begin
            bus_rd(5'd1, d);
            chk("R3 busy reads 1 during job", d[1], 1'b1);
            bus_wr(5'd0, 32'hFFFF_FFFF, 4'hF);
            bus_wr(5'd2, 32'h0, 4'hF);
            bus_wr(5'd16, 32'hDEAD_BEEF, 4'hF);
            bus_wr(5'd1, 32'h0000_3301, 4'b0011);
        end
        wait_idle();
        if (!tx) for (int b = 0; b < ne; b++) tb_buf[b] = pat(b, sd);
        chk({req, " MOSI stream mismatches"}, mism, 0);
        chk({req, " SCLK rising edges"}, seen, nbits);
        chk("R7 chip select used", cs_used, cs ? 2'b01 : 2'b10);
        chk("R8 select leads first clock", gap_ok, 1'b1);
        if (poke) begin
            repeat (30) @(negedge clk);
            chk("R9 no second job after ignored start", csn, 2'b11);
            bus_rd(5'd0, d);
            chk("R9 config kept while busy", d, cfg);
            bus_rd(5'd2, d);
            chk("R9 address kept while busy", d, adr);
            bus_rd(5'd1, d);
            chk("R9 opcode kept while busy", d[15:8], op);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R3 act=running exp=idle");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        bus_rd(5'd0, d);  chk("R1 config reset", d, 32'h0);
        bus_rd(5'd1, d);  chk("R1 control reset", d, 32'h0000_0030);
        bus_rd(5'd2, d);  chk("R1 address reset", d, 32'h0);
        chk("R7 selects idle high", {30'h0, csn, sclk}, 32'h6);

        bus_wr(5'd1, 32'h0000_0001, 4'b0001);
        repeat (3) @(negedge clk);
        bus_rd(5'd1, d);
        chk("R3 start refused in automatic mode", {d[5:4], d[1]}, 3'b110);
        chk("R3 no select in automatic mode", csn, 2'b11);

        bus_wr(5'd1, 32'h0, 4'b0001);
        bus_rd(5'd1, d);  chk("R2 clear refused without unlock", d[5:4], 2'b11);

        bus_wr(5'd1, 32'h0000_5500, 4'b0010);
        bus_wr(5'd1, 32'h0000_1200, 4'b0010);
        bus_wr(5'd1, 32'h0000_AA00, 4'b0010);
        bus_wr(5'd1, 32'h0, 4'b0001);
        bus_rd(5'd1, d);  chk("R2 broken unlock refused", d[5:4], 2'b11);

        bus_wr(5'd1, 32'h0000_5500, 4'b0010);
        bus_wr(5'd1, 32'h0000_AA00, 4'b0010);
        bus_wr(5'd1, 32'h0, 4'b0001);
        bus_rd(5'd1, d);  chk("R2 unlocked clear accepted", d, 32'h0000_AA00);

        run_job("R6 opcode only", 8'hE9, 3'd0, 5'd0, 8'd0, 1'b0, 1'b0, 32'h0, 8'h00, 1'b0);

        fill_buf(8'h11);
        run_job("R5 transmit 3-byte address", 8'h02, 3'd3, 5'd0, 8'd5, 1'b1, 1'b1,
                32'h0012_3456, 8'h00, 1'b0);
        chk_buf("R5 transmit leaves buffer");

        run_job("R4 fast read with dummy", 8'h0B, 3'd3, 5'd8, 8'd64, 1'b0, 1'b0,
                32'h0000_1000, 8'h47, 1'b0);
        chk_buf("R5 receive fill");

        fill_buf(8'h6E);
        run_job("R4 address length above 4", 8'h12, 3'd6, 5'd3, 8'd2, 1'b1, 1'b0,
                32'hA1B2_C3D4, 8'h00, 1'b0);

        run_job("R6 count above 64", 8'h03, 3'd3, 5'd0, 8'd100, 1'b0, 1'b1,
                32'h0000_0040, 8'h9D, 1'b0);
        chk_buf("R6 capped receive");

        run_job("R9 writes during job", 8'h03, 3'd3, 5'd0, 8'd8, 1'b0, 1'b0,
                32'h0000_0777, 8'h2B, 1'b1);
        chk_buf("R9 buffer not overwritten by host");

        bus_wr(5'd1, 32'h0000_0030, 4'b0001);
        bus_rd(5'd1, d);  chk("R2 relock always accepted", d[5:4], 2'b11);
        bus_wr(5'd1, 32'h0000_0001, 4'b0001);
        repeat (3) @(negedge clk);
        bus_rd(5'd1, d);  chk("R3 start refused after relock", d[1], 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule